// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Identity Register

This block collects interrupt events in two stages. A child identity register latches per-source events. Each child bit holds its visible event plus at most one further event waiting behind it. The child bits that hold anything and are enabled are ORed into one summary line. A rising edge on that summary sets one bit of a parent identity register. The other parent bits latch their own direct event inputs, and they use the same per-bit storage rules as the child bits.

Software clears identity bits by writing ones to them. When a cleared bit still has an event waiting, it reads zero for one cycle and then sets again. The parent bit fed by the child only reacts to edges of the summary. Because of this, software must drain every child bit, waiting events included, before a later child event can raise the parent bit again. Another way to re-arm the parent bit is to switch the child enables off and then back on while child events are still held. The CPU interrupt line is the OR of the enabled parent bits, and a global enable gates it.

Top module: `irq_cascade`

## Requirements
- R1: A child or parent event whose mask bit is 1 is not latched. The bit keeps reading 0, and the same event with the mask bit at 0 sets it.
- R2: An unmasked event sets its identity bit, which reads 1 in the cycle after the event is sampled.
- R3: Each bit stores two events: the visible one and one waiting. A third event that arrives while both slots are full is dropped, and the overflow flag for that bit sets one cycle later and stays set until reset.
- R4: Writing 1 to clear a visible bit that has a waiting event makes the bit read 0 for exactly one cycle and then 1 again, and the waiting slot empties. A second clear then leaves the bit at 0.
- R5: An event that arrives in the same cycle as the clear of its visible bit is kept. The bit reads 0 for one cycle and then 1.
- R6: The child summary is the OR over all child bits of (bit holds a visible or waiting event AND child enable). A rising edge of the summary sets parent bit SUM_BIT. This bit reads 1 two cycles after the child event is sampled.
- R7: Clearing parent bit SUM_BIT while the child summary stays high leaves that bit at 0.
- R8: Parent bit SUM_BIT stays 0 while a child bit is being drained through its waiting event. After every child bit is empty, a new child event sets the parent bit again.
- R9: Turning the child enables off and then on while child events are held sets parent bit SUM_BIT two cycles after the re-enable write. The child identity bits are unchanged.
- R10: irq_o is 1 exactly when the global enable is 1 and at least one parent bit is both set and enabled. Enable writes take effect in the next cycle.
- R11: Reset clears every identity bit, every waiting slot, every overflow flag, all enables, all masks and the stored summary used for edge detection.
- R12: The other parent bits latch par_evt_i directly. Input par_evt_i[SUM_BIT] has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| child_evt_i | input | N_CHILD | Child source event pulses |
| child_en_we_i | input | 1 | Write strobe for child enables |
| child_en_i | input | N_CHILD | Child enable write data |
| child_msk_we_i | input | 1 | Write strobe for child masks |
| child_msk_i | input | N_CHILD | Child mask write data (1 = block latching) |
| child_clr_i | input | N_CHILD | Write-one-to-clear strobes for child identity bits |
| par_evt_i | input | N_PARENT | Direct parent event pulses (bit SUM_BIT unused) |
| par_en_we_i | input | 1 | Write strobe for parent enables |
| par_en_i | input | N_PARENT | Parent enable write data |
| par_msk_we_i | input | 1 | Write strobe for parent masks |
| par_msk_i | input | N_PARENT | Parent mask write data |
| par_clr_i | input | N_PARENT | Write-one-to-clear strobes for parent identity bits |
| glb_en_we_i | input | 1 | Write strobe for global enable |
| glb_en_i | input | 1 | Global enable write data |
| child_id_o | output | N_CHILD | Child identity readback |
| par_id_o | output | N_PARENT | Parent identity readback |
| child_ovf_o | output | N_CHILD | Sticky child overflow flags |
| par_ovf_o | output | N_PARENT | Sticky parent overflow flags |
| irq_o | output | 1 | Interrupt to the CPU |

## Verification
The bench first drives a single child event and checks the identity bit, the parent bit and the interrupt line. This confirms the two-cycle path through the edge detector. It then drives a double event followed by two clears, which tells apart a bit that reloads from its waiting slot from one that simply clears. The same pattern shows that the parent bit stays low while the summary never falls. A burst of three events separates storage from overflow, and a clear that coincides with a new event shows that the event is not lost. An enable off/on toggle, a masked event and global gating complete the set, and each of them changes only one thing against an otherwise identical case.

// File: rtl/irq_cascade_pkg.sv
`timescale 1ns/1ps
package irq_cascade_pkg;
  // events held per identity bit: visible plus one waiting
  typedef logic [1:0] hold_t;
  localparam hold_t HOLD_MAX = 2'd2;
endpackage

// File: rtl/irq_id_cell.sv
`timescale 1ns/1ps
module irq_id_cell
  import irq_cascade_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic vis_o,
  output logic held_o,
  output logic ovf_o
);
  logic  vis_q, vis_d, ovf_q, ovf_d;
  hold_t cnt_q, cnt_d;
  logic  take, reload;

  assign take   = clr_i & vis_q;
  assign reload = (cnt_q != '0) & ~vis_q;

  always_comb begin
    vis_d = vis_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (take) begin
      // visible event retired; a waiting or same-cycle event reappears next cycle
      cnt_d = hold_t'(cnt_q + hold_t'(evt_i) - hold_t'(1));
      vis_d = 1'b0;
    end else if (evt_i && cnt_q == HOLD_MAX) begin
      ovf_d = 1'b1;
      vis_d = 1'b1;
    end else begin
      cnt_d = hold_t'(cnt_q + hold_t'(evt_i));
      vis_d = vis_q | reload | evt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q <= 1'b0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vis_q <= vis_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign vis_o  = vis_q;
  assign held_o = (cnt_q != '0);
  assign ovf_o  = ovf_q;

  p_vis_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_o |-> held_o);
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cnt_q == HOLD_MAX && !evt_i) |=> (!vis_o ##1 vis_o));
  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && evt_i) |=> held_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == HOLD_MAX && evt_i && !take) |=> ovf_o);
  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/irq_id_bank.sv
`timescale 1ns/1ps
module irq_id_bank #(
  parameter int unsigned W        = 8,
  parameter bit          SUM_HELD = 1'b1  // 1: summary over held events, 0: over visible bits
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_i,
  input  logic         msk_we_i,
  input  logic [W-1:0] msk_i,
  output logic [W-1:0] id_o,
  output logic [W-1:0] ovf_o,
  output logic         sum_o
);
  logic [W-1:0] en_q, msk_q, held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      msk_q <= '0;
    end else begin
      if (en_we_i)  en_q  <= en_i;
      if (msk_we_i) msk_q <= msk_i;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    irq_id_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[g] & ~msk_q[g]),
      .clr_i  (clr_i[g]),
      .vis_o  (id_o[g]),
      .held_o (held[g]),
      .ovf_o  (ovf_o[g])
    );

    p_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msk_q[g] && !held[g] && !msk_we_i) |=> !held[g]);
  end

  if (SUM_HELD) begin : g_sum_held
    assign sum_o = |(held & en_q);
  end else begin : g_sum_vis
    assign sum_o = |(id_o & en_q);
  end
endmodule

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  p_rise_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_level_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lvl_i) && lvl_i) |-> !rise_o);
endmodule

// File: rtl/irq_cascade.sv
`timescale 1ns/1ps
module irq_cascade #(
  parameter int unsigned N_CHILD  = 8,
  parameter int unsigned N_PARENT = 4,
  parameter int unsigned SUM_BIT  = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CHILD-1:0]  child_evt_i,
  input  logic                child_en_we_i,
  input  logic [N_CHILD-1:0]  child_en_i,
  input  logic                child_msk_we_i,
  input  logic [N_CHILD-1:0]  child_msk_i,
  input  logic [N_CHILD-1:0]  child_clr_i,
  input  logic [N_PARENT-1:0] par_evt_i,
  input  logic                par_en_we_i,
  input  logic [N_PARENT-1:0] par_en_i,
  input  logic                par_msk_we_i,
  input  logic [N_PARENT-1:0] par_msk_i,
  input  logic [N_PARENT-1:0] par_clr_i,
  input  logic                glb_en_we_i,
  input  logic                glb_en_i,
  output logic [N_CHILD-1:0]  child_id_o,
  output logic [N_PARENT-1:0] par_id_o,
  output logic [N_CHILD-1:0]  child_ovf_o,
  output logic [N_PARENT-1:0] par_ovf_o,
  output logic                irq_o
);
  logic                child_sum, child_rise, par_act, glb_en_q;
  logic [N_PARENT-1:0] par_evt;
  logic                unused_par_evt;

  assign unused_par_evt = par_evt_i[SUM_BIT];

  irq_id_bank #(.W(N_CHILD), .SUM_HELD(1'b1)) u_child (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (child_evt_i),
    .clr_i    (child_clr_i),
    .en_we_i  (child_en_we_i),
    .en_i     (child_en_i),
    .msk_we_i (child_msk_we_i),
    .msk_i    (child_msk_i),
    .id_o     (child_id_o),
    .ovf_o    (child_ovf_o),
    .sum_o    (child_sum)
  );

  irq_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (child_sum),
    .rise_o (child_rise)
  );

  always_comb begin
    par_evt          = par_evt_i;
    par_evt[SUM_BIT] = child_rise;
  end

  irq_id_bank #(.W(N_PARENT), .SUM_HELD(1'b0)) u_parent (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (par_evt),
    .clr_i    (par_clr_i),
    .en_we_i  (par_en_we_i),
    .en_i     (par_en_i),
    .msk_we_i (par_msk_we_i),
    .msk_i    (par_msk_i),
    .id_o     (par_id_o),
    .ovf_o    (par_ovf_o),
    .sum_o    (par_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          glb_en_q <= 1'b0;
    else if (glb_en_we_i) glb_en_q <= glb_en_i;
  end

  assign irq_o = glb_en_q & par_act;

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_q |-> !irq_o);
  p_irq_needs_id_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (par_id_o != '0));
endmodule

// File: tb/irq_cascade_tb.sv
`timescale 1ns/1ps
module irq_cascade_tb;
  localparam int NC = 8;
  localparam int NP = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] child_evt_i = '0, child_en_i = '0, child_msk_i = '0, child_clr_i = '0;
  logic [NP-1:0] par_evt_i = '0, par_en_i = '0, par_msk_i = '0, par_clr_i = '0;
  logic          child_en_we_i = 1'b0, child_msk_we_i = 1'b0;
  logic          par_en_we_i = 1'b0, par_msk_we_i = 1'b0;
  logic          glb_en_we_i = 1'b0, glb_en_i = 1'b0;
  logic [NC-1:0] child_id_o, child_ovf_o;
  logic [NP-1:0] par_id_o, par_ovf_o;
  logic          irq_o;

  irq_cascade #(.N_CHILD(NC), .N_PARENT(NP), .SUM_BIT(0)) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // sel: 0 child_id, 1 par_id, 2 child_ovf, 3 par_ovf, 4 irq
  typedef struct {
    int    due;
    int    sel;
    int    idx;
    logic  val;
    string req;
  } item_t;
  item_t sb_q[$];

  function automatic logic pick(int sel, int idx);
    case (sel)
      0: return child_id_o[idx];
      1: return par_id_o[idx];
      2: return child_ovf_o[idx];
      3: return par_ovf_o[idx];
      default: return irq_o;
    endcase
  endfunction

  task automatic expect_v(string req, int sel, int idx, logic val, int dly);
    item_t it;
    int pos;
    it = '{cyc + dly, sel, idx, val, req};
    pos = sb_q.size();
    while (pos > 0 && sb_q[pos-1].due > it.due) pos--;
    sb_q.insert(pos, it);
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk_i) begin
    item_t it;
    logic  act;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      it  = sb_q.pop_front();
      act = pick(it.sel, it.idx);
      total++;
      if (it.due < cyc || act !== it.val) begin
        bad++;
        $display("FAIL %s sel=%0d idx=%0d actual=%b expected=%b cyc=%0d",
                 it.req, it.sel, it.idx, act, it.val, cyc);
      end
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
    child_evt_i = '0; child_clr_i = '0; par_evt_i = '0; par_clr_i = '0;
    child_en_we_i = 1'b0; child_msk_we_i = 1'b0;
    par_en_we_i = 1'b0; par_msk_we_i = 1'b0; glb_en_we_i = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drain_child();
    for (int i = 0; i < 6; i++) begin child_clr_i = '1; tick(); end
    tick();
  endtask

  task automatic drain_par();
    for (int i = 0; i < 6; i++) begin par_clr_i = '1; tick(); end
    tick();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R11 reset state
    for (int i = 0; i < NC; i++) begin
      expect_v("R11", 0, i, 1'b0, 0);
      expect_v("R11", 2, i, 1'b0, 0);
    end
    for (int i = 0; i < NP; i++) expect_v("R11", 1, i, 1'b0, 0);
    expect_v("R11", 4, 0, 1'b0, 0);
    tick();

    glb_en_we_i = 1; glb_en_i = 1;
    par_en_we_i = 1; par_en_i = '1;
    child_en_we_i = 1; child_en_i = '1;
    tick();

    // R2 R6 R10: single child event
    child_evt_i[1] = 1;
    expect_v("R2", 0, 1, 1'b1, 1);
    expect_v("R6", 1, 0, 1'b0, 1);
    expect_v("R6", 1, 0, 1'b1, 2);
    expect_v("R10", 4, 0, 1'b1, 2);
    ticks(3);

    // R7: clear parent while child summary high
    par_clr_i[0] = 1;
    expect_v("R7", 1, 0, 1'b0, 1);
    expect_v("R7", 1, 0, 1'b0, 3);
    expect_v("R10", 4, 0, 1'b0, 1);
    ticks(4);

    // R4 R8: waiting event reloads; parent stays low
    child_evt_i[1] = 1;
    tick();
    child_clr_i[1] = 1;
    expect_v("R4", 0, 1, 1'b0, 1);
    expect_v("R4", 0, 1, 1'b1, 2);
    expect_v("R8", 1, 0, 1'b0, 1);
    expect_v("R8", 1, 0, 1'b0, 2);
    ticks(2);
    child_clr_i[1] = 1;
    expect_v("R4", 0, 1, 1'b0, 1);
    expect_v("R4", 0, 1, 1'b0, 3);
    expect_v("R8", 1, 0, 1'b0, 3);
    ticks(4);
    child_evt_i[2] = 1;
    expect_v("R8", 1, 0, 1'b1, 2);
    ticks(3);

    // R9: enable toggle re-arms parent
    par_clr_i[0] = 1;
    tick();
    child_en_we_i = 1; child_en_i = '0;
    tick();
    child_en_we_i = 1; child_en_i = '1;
    expect_v("R9", 1, 0, 1'b0, 1);
    expect_v("R9", 1, 0, 1'b1, 2);
    expect_v("R9", 0, 2, 1'b1, 1);
    ticks(3);
    drain_child();
    drain_par();

    // R3: third event overflows
    child_evt_i[3] = 1;
    expect_v("R3", 2, 3, 1'b0, 2);
    expect_v("R3", 2, 3, 1'b1, 3);
    tick();
    child_evt_i[3] = 1;
    tick();
    child_evt_i[3] = 1;
    ticks(2);
    child_clr_i[3] = 1;
    expect_v("R3", 0, 3, 1'b0, 1);
    expect_v("R3", 0, 3, 1'b1, 2);
    ticks(2);
    child_clr_i[3] = 1;
    expect_v("R3", 0, 3, 1'b0, 1);
    expect_v("R3", 0, 3, 1'b0, 3);
    expect_v("R3", 2, 3, 1'b1, 3);
    ticks(4);
    drain_par();

    // R5: event in the clear cycle is kept
    child_evt_i[4] = 1;
    tick();
    child_clr_i[4] = 1; child_evt_i[4] = 1;
    expect_v("R5", 0, 4, 1'b0, 1);
    expect_v("R5", 0, 4, 1'b1, 2);
    ticks(2);
    child_clr_i[4] = 1;
    expect_v("R5", 0, 4, 1'b0, 1);
    expect_v("R5", 0, 4, 1'b0, 3);
    ticks(4);

    // R1: mask blocks latching
    child_msk_we_i = 1; child_msk_i = 8'b0010_0000;
    tick();
    child_evt_i[5] = 1;
    expect_v("R1", 0, 5, 1'b0, 1);
    expect_v("R1", 0, 5, 1'b0, 2);
    ticks(3);
    child_msk_we_i = 1; child_msk_i = '0;
    tick();
    child_evt_i[5] = 1;
    expect_v("R1", 0, 5, 1'b1, 1);
    ticks(2);
    drain_child();
    drain_par();

    // R10 R12: direct parent bit and gating
    par_evt_i[1] = 1;
    expect_v("R12", 1, 1, 1'b1, 1);
    expect_v("R10", 4, 0, 1'b1, 1);
    tick();
    glb_en_we_i = 1; glb_en_i = 0;
    expect_v("R10", 4, 0, 1'b0, 1);
    tick();
    glb_en_we_i = 1; glb_en_i = 1;
    expect_v("R10", 4, 0, 1'b1, 1);
    tick();
    par_en_we_i = 1; par_en_i = 4'b1101;
    expect_v("R10", 4, 0, 1'b0, 1);
    expect_v("R10", 1, 1, 1'b1, 1);
    tick();
    par_en_we_i = 1; par_en_i = '1;
    tick();
    drain_par();

    // R12: direct input on the summary bit is ignored
    par_evt_i[0] = 1;
    expect_v("R12", 1, 0, 1'b0, 1);
    expect_v("R12", 1, 0, 1'b0, 2);
    expect_v("R12", 4, 0, 1'b0, 1);
    ticks(3);

    ticks(4);
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R2 pending expectations actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule